// File: doc/BRIEF.md
# FMA NaN Result Selector

This block decides the NaN result of a single-precision fused multiply-add of the form A*B+C. It looks at the three operands and finds which are NaNs, which are signalling NaNs, and whether the product is an infinity times a zero. It then applies run-time rules to pick the result NaN. One rule is a packed priority word that orders the operands and can prefer signalling NaNs. A second rule covers infinity times zero plus a NaN. A default-NaN mode forces a generated NaN whenever the result is a NaN. The default NaN is built from an 8-bit pattern.

The block reports whether the result is a NaN, the 32-bit NaN value, an invalid-operation flag and a configuration-error flag. The decision itself is combinational. It falls into one of four kinds:

- `PICK_NONE`: the result is not a NaN.
- `PICK_INPUT`: an input NaN is forwarded, quieted.
- `PICK_DEFAULT`: the generated default NaN.
- `PICK_FAULT`: the rules are missing or malformed.

The kind is chosen afresh on every strobed input. No kind persists from one input to the next. The outputs are captured in a single register stage when the input strobe is high. The arithmetic datapath, rounding and non-NaN results belong to other blocks.

Top module: `fma_nan_select`

## Requirements
- R1: Outputs reset to zero. They load only at a rising edge where `in_valid` is high, so results appear one clock after the strobed cycle. They hold their value while `in_valid` is low.
- R2: An operand is a NaN when its exponent bits [30:23] are all ones and its fraction [22:0] is non-zero. It is quiet when bit 22 is 1 and signalling otherwise. `res_nan` is 1 when any operand is a NaN or when A*B is an infinity times a zero (either order, either sign).
- R3: Operand indices are A=0, B=1 and C=2. `prop_rule[1:0]` holds the first-choice index, `[3:2]` the second and `[5:4]` the third. The first listed operand that is a NaN wins. It is output with bit 22 forced to 1 and all other bits unchanged.
- R4: When `prop_rule[6]` is 1 and at least one operand is a signalling NaN, only the signalling NaNs are candidates for the ordering. When `prop_rule[6]` is 0, quiet and signalling NaNs compete on order alone.
- R5: An input NaN must be picked in two faulting cases. One is when `prop_rule` is zero. The other is when no ordering field names a NaN operand; a field value of 3 names no operand. In either case `flag_cfg_err` is 1 and `res_val` is 0x7FC00000.
- R6: When `dnan_mode` is 1, every NaN result is the default NaN. `prop_rule` and `izn_rule` have no effect, and a zero rule raises no error.
- R7: For an infinity times zero plus a NaN C, `izn_rule` selects the result. Code 0 is a fault (R5 output). Code 1 returns C quieted. Code 2 returns the default NaN. Code 3 returns the default NaN if C is quiet and C quieted if C is signalling.
- R8: An infinity times zero with a non-NaN C returns the default NaN, whatever `prop_rule` holds.
- R9: The default NaN is built as follows:
  - bit 31 is `dnan_pat[7]`;
  - bits [30:23] are all ones;
  - bits [22:16] are `dnan_pat[6:0]`;
  - bits [15:0] are copies of `dnan_pat[0]`.
- R10: When a default NaN is needed and `dnan_pat[6:0]` is zero, `flag_cfg_err` is 1 and `res_val` is 0x7FC00000.
- R11: `flag_invalid` is 1 when any operand is a signalling NaN or when A*B is an infinity times a zero, and 0 otherwise.
- R12: When the result is not a NaN, `res_nan`, `res_val`, `flag_invalid` and `flag_cfg_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe that loads the output register |
| op_a | input | 32 | Multiplicand A |
| op_b | input | 32 | Multiplier B |
| op_c | input | 32 | Addend C |
| prop_rule | input | 7 | Three 2-bit operand priority fields and a signalling-preference bit |
| izn_rule | input | 2 | Rule for infinity times zero plus NaN |
| dnan_mode | input | 1 | Force the default NaN for all NaN results |
| dnan_pat | input | 8 | Default-NaN pattern: sign and upper fraction bits |
| res_nan | output | 1 | Result is a NaN |
| res_val | output | 32 | NaN result value, zero when not a NaN |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_cfg_err | output | 1 | Missing or malformed rule or pattern |

## Verification
Every result and flag is due exactly one clock after the cycle in which `in_valid` was high, because the only register on the path is the output stage. The bench therefore drives each stimulus on a falling edge with the strobe high. It drops the strobe on the next falling edge and compares all four outputs there, half a period after the loading edge. Hold behaviour is checked by changing the operands on further falling edges with the strobe low and confirming that the outputs keep their earlier values.

// File: rtl/fnan_sel_pkg.sv
package fnan_sel_pkg;

    localparam int N_OPS  = 3;
    localparam int IDX_W  = 2;
    localparam int ADD_IX = 2;

    localparam logic [1:0] IZN_UNSET       = 2'd0;
    localparam logic [1:0] IZN_KEEP_INPUT  = 2'd1;
    localparam logic [1:0] IZN_ALWAYS_DFLT = 2'd2;
    localparam logic [1:0] IZN_DFLT_IF_Q   = 2'd3;

    typedef enum logic [1:0] {
        PICK_NONE    = 2'd0,
        PICK_INPUT   = 2'd1,
        PICK_DEFAULT = 2'd2,
        PICK_FAULT   = 2'd3
    } pick_kind_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } op_class_t;

endpackage

// File: rtl/fnan_classify.sv
module fnan_classify
    import fnan_sel_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val,
    output op_class_t            cls
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max;
    logic             man_nz;

    assign exp_f   = val[W-2 -: EXP_W];
    assign man_f   = val[MAN_W-1:0];
    assign exp_max = &exp_f;
    assign man_nz  = |man_f;

    always_comb begin
        cls.is_nan  = exp_max & man_nz;
        cls.is_snan = exp_max & man_nz & ~man_f[MAN_W-1];
        cls.is_inf  = exp_max & ~man_nz;
        cls.is_zero = ~(|exp_f) & ~man_nz;
    end

endmodule

// File: rtl/fnan_pick.sv
module fnan_pick
    import fnan_sel_pkg::*;
#(
    parameter int RULE_W = N_OPS * IDX_W + 1
) (
    input  logic [RULE_W-1:0] rule,
    input  logic [N_OPS-1:0]  nan_vec,
    input  logic [N_OPS-1:0]  snan_vec,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    localparam int PREF_BIT = RULE_W - 1;

    logic [N_OPS-1:0] cand;
    logic [N_OPS-1:0] slot_hit;
    logic [IDX_W-1:0] slot_sel [N_OPS];

    assign cand = (rule[PREF_BIT] && (|snan_vec)) ? snan_vec : nan_vec;

    generate
        for (genvar s = 0; s < N_OPS; s++) begin : g_slot
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int j = 0; j < N_OPS; j++) begin
                    if (rule[s*IDX_W +: IDX_W] == IDX_W'(j) && cand[j]) hit = 1'b1;
                end
            end
            assign slot_sel[s] = rule[s*IDX_W +: IDX_W];
            assign slot_hit[s] = hit;
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int s = N_OPS - 1; s >= 0; s--) begin
            if (slot_hit[s]) begin
                found = 1'b1;
                idx   = slot_sel[s];
            end
        end
    end

endmodule

// File: rtl/fnan_dnan.sv
module fnan_dnan #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int PAT_W = 8
) (
    input  logic [PAT_W-1:0]     pat,
    output logic [EXP_W+MAN_W:0] dn,
    output logic                 ok
);
    localparam int FILL_W = MAN_W - (PAT_W - 1);

    assign dn = {pat[PAT_W-1], {EXP_W{1'b1}}, pat[PAT_W-2:0], {FILL_W{pat[0]}}};
    assign ok = |pat[PAT_W-2:0];

endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
    import fnan_sel_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int PAT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [EXP_W+MAN_W:0]        op_a,
    input  logic [EXP_W+MAN_W:0]        op_b,
    input  logic [EXP_W+MAN_W:0]        op_c,
    input  logic [N_OPS*IDX_W:0]        prop_rule,
    input  logic [1:0]                  izn_rule,
    input  logic                        dnan_mode,
    input  logic [PAT_W-1:0]            dnan_pat,
    output logic                        res_nan,
    output logic [EXP_W+MAN_W:0]        res_val,
    output logic                        flag_invalid,
    output logic                        flag_cfg_err
);
    localparam int W      = 1 + EXP_W + MAN_W;
    localparam int RULE_W = N_OPS * IDX_W + 1;
    localparam logic [W-1:0] QUIET_MASK = W'(1) << (MAN_W - 1);
    localparam logic [W-1:0] FAULT_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [W-1:0]     ops [N_OPS];
    op_class_t        cls [N_OPS];
    logic [N_OPS-1:0] nan_vec;
    logic [N_OPS-1:0] snan_vec;
    logic             inf_zero;
    logic             any_nan;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic [W-1:0]     dflt_nan;
    logic             dflt_ok;

    pick_kind_e       kind;
    logic [IDX_W-1:0] src_idx;
    logic [W-1:0]     src_val;

    logic             nxt_nan;
    logic [W-1:0]     nxt_val;
    logic             nxt_inv;
    logic             nxt_err;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    generate
        for (genvar i = 0; i < N_OPS; i++) begin : g_cls
            fnan_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
                .val (ops[i]),
                .cls (cls[i])
            );
            assign nan_vec[i]  = cls[i].is_nan;
            assign snan_vec[i] = cls[i].is_snan;
        end
    endgenerate

    assign inf_zero = (cls[0].is_inf & cls[1].is_zero) | (cls[0].is_zero & cls[1].is_inf);
    assign any_nan  = |nan_vec;

    fnan_pick #(.RULE_W(RULE_W)) pick_i (
        .rule     (prop_rule),
        .nan_vec  (nan_vec),
        .snan_vec (snan_vec),
        .found    (pick_found),
        .idx      (pick_idx)
    );

    fnan_dnan #(.EXP_W(EXP_W), .MAN_W(MAN_W), .PAT_W(PAT_W)) dnan_i (
        .pat (dnan_pat),
        .dn  (dflt_nan),
        .ok  (dflt_ok)
    );

    // Decision: which kind of result this input set produces.
    always_comb begin
        kind    = PICK_NONE;
        src_idx = pick_idx;
        if (!any_nan && !inf_zero) begin
            kind = PICK_NONE;
        end else if (dnan_mode) begin
            kind = PICK_DEFAULT;
        end else if (inf_zero && nan_vec[ADD_IX]) begin
            src_idx = IDX_W'(ADD_IX);
            unique case (izn_rule)
                IZN_UNSET:       kind = PICK_FAULT;
                IZN_KEEP_INPUT:  kind = PICK_INPUT;
                IZN_ALWAYS_DFLT: kind = PICK_DEFAULT;
                IZN_DFLT_IF_Q:   kind = snan_vec[ADD_IX] ? PICK_INPUT : PICK_DEFAULT;
                default:         kind = PICK_FAULT;
            endcase
        end else if (inf_zero) begin
            kind = PICK_DEFAULT;
        end else if (prop_rule == '0 || !pick_found) begin
            kind = PICK_FAULT;
        end else begin
            kind = PICK_INPUT;
        end
        if (kind == PICK_DEFAULT && !dflt_ok) kind = PICK_FAULT;
    end

    always_comb begin
        src_val = '0;
        for (int j = 0; j < N_OPS; j++) begin
            if (src_idx == IDX_W'(j)) src_val = ops[j];
        end
    end

    // Output forming per decision kind.
    always_comb begin
        nxt_inv = (|snan_vec) | inf_zero;
        nxt_nan = 1'b1;
        nxt_err = 1'b0;
        nxt_val = '0;
        unique case (kind)
            PICK_NONE: begin
                nxt_nan = 1'b0;
                nxt_inv = 1'b0;
            end
            PICK_INPUT:   nxt_val = src_val | QUIET_MASK;
            PICK_DEFAULT: nxt_val = dflt_nan;
            PICK_FAULT: begin
                nxt_val = FAULT_NAN;
                nxt_err = 1'b1;
            end
            default: nxt_nan = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_nan      <= 1'b0;
            res_val      <= '0;
            flag_invalid <= 1'b0;
            flag_cfg_err <= 1'b0;
        end else if (in_valid) begin
            res_nan      <= nxt_nan;
            res_val      <= nxt_val;
            flag_invalid <= nxt_inv;
            flag_cfg_err <= nxt_err;
        end
    end

endmodule

// File: rtl/fnan_sel_checker.sv
module fnan_sel_checker #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int PAT_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [EXP_W+MAN_W:0] op_a,
    input logic [EXP_W+MAN_W:0] op_b,
    input logic [EXP_W+MAN_W:0] op_c,
    input logic                 dnan_mode,
    input logic [PAT_W-1:0]     dnan_pat,
    input logic                 res_nan,
    input logic [EXP_W+MAN_W:0] res_val,
    input logic                 flag_invalid,
    input logic                 flag_cfg_err
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic armed;
    logic in_snan;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    function automatic logic sig_nan(input logic [W-1:0] v);
        return (&v[W-2 -: EXP_W]) && (|v[MAN_W-1:0]) && !v[MAN_W-1];
    endfunction

    assign in_snan = sig_nan(op_a) | sig_nan(op_b) | sig_nan(op_c);

    // R1: outputs hold while the strobe is low
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !in_valid) |=> ($stable(res_val) && $stable(res_nan)
                                  && $stable(flag_invalid) && $stable(flag_cfg_err)));

    // R2: a flagged NaN result is encoded as a NaN
    a_r2_nan_encoding: assert property (@(posedge clk) disable iff (!rst_n)
        res_nan |-> ((&res_val[W-2 -: EXP_W]) && (|res_val[MAN_W-1:0])));

    // R12: non-NaN results are all zero
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !res_nan |-> (res_val == '0 && !flag_cfg_err && !flag_invalid));

    // R11: a signalling input raises invalid
    a_r11_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_snan) |=> flag_invalid);

    // R6: default-NaN mode with a usable pattern never faults
    a_r6_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dnan_mode && (|dnan_pat[PAT_W-2:0])) |=> !flag_cfg_err);

endmodule

bind fma_nan_select fnan_sel_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W), .PAT_W(PAT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op_a         (op_a),
    .op_b         (op_b),
    .op_c         (op_c),
    .dnan_mode    (dnan_mode),
    .dnan_pat     (dnan_pat),
    .res_nan      (res_nan),
    .res_val      (res_val),
    .flag_invalid (flag_invalid),
    .flag_cfg_err (flag_cfg_err)
);

// File: tb/fma_nan_select_tb.sv
`timescale 1ns/1ps
module fma_nan_select_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic [6:0]  prop_rule = '0;
    logic [1:0]  izn_rule = '0;
    logic        dnan_mode = 1'b0;
    logic [7:0]  dnan_pat = '0;
    logic        res_nan;
    logic [31:0] res_val;
    logic        flag_invalid;
    logic        flag_cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    fma_nan_select dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .prop_rule(prop_rule), .izn_rule(izn_rule),
        .dnan_mode(dnan_mode), .dnan_pat(dnan_pat),
        .res_nan(res_nan), .res_val(res_val),
        .flag_invalid(flag_invalid), .flag_cfg_err(flag_cfg_err)
    );

    localparam logic [31:0] NUM_ONE = 32'h3F800000;
    localparam logic [31:0] POS_INF = 32'h7F800000;
    localparam logic [31:0] FAULT_V = 32'h7FC00000;

    // {res_nan, flag_invalid, flag_cfg_err, res_val}
    function automatic logic [34:0] model(input logic [31:0] a, b, c,
                                          input logic [6:0] r, input logic [1:0] iz,
                                          input logic dm, input logic [7:0] p);
        logic [31:0] v [3];
        logic        n [3];
        logic        s [3];
        logic        izc, anyn, anys, dn_ok, inv;
        logic [31:0] dn;
        int          pick, mode, f;
        v[0] = a; v[1] = b; v[2] = c;
        for (int i = 0; i < 3; i++) begin
            n[i] = (v[i][30:23] == 8'hFF) && (v[i][22:0] != 0);
            s[i] = n[i] && !v[i][22];
        end
        izc  = (a[30:0] == 31'h7F800000 && b[30:0] == 0) || (a[30:0] == 0 && b[30:0] == 31'h7F800000);
        anyn = n[0] | n[1] | n[2];
        anys = s[0] | s[1] | s[2];
        inv  = anys | izc;
        dn    = {p[7], 8'hFF, p[6:0], p[0] ? 16'hFFFF : 16'h0000};
        dn_ok = (p[6:0] != 0);
        if (!anyn && !izc) return 35'd0;
        pick = 2;
        if (dm) mode = 1;
        else if (izc && n[2]) begin
            case (iz)
                2'd0: mode = 2;
                2'd1: mode = 0;
                2'd2: mode = 1;
                default: mode = s[2] ? 0 : 1;
            endcase
        end else if (izc) mode = 1;
        else if (r == 0) mode = 2;
        else begin
            pick = -1;
            for (int k = 0; k < 3; k++) begin
                f = (int'(r) >> (2 * k)) & 3;
                if (pick < 0 && f < 3 && ((r[6] && anys) ? s[f] : n[f])) pick = f;
            end
            mode = (pick < 0) ? 2 : 0;
        end
        if (mode == 1 && !dn_ok) mode = 2;
        case (mode)
            0:       return {1'b1, inv, 1'b0, v[pick] | 32'h00400000};
            1:       return {1'b1, inv, 1'b0, dn};
            default: return {1'b1, inv, 1'b1, FAULT_V};
        endcase
    endfunction

    task automatic check(input string tag, input logic [34:0] expv);
        logic [34:0] got;
        got = {res_nan, flag_invalid, flag_cfg_err, res_val};
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, expv);
        end
    endtask

    task automatic drive(input logic [31:0] a, b, c, input logic [6:0] r,
                         input logic [1:0] iz, input logic dm, input logic [7:0] p);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c;
        prop_rule = r; izn_rule = iz; dnan_mode = dm; dnan_pat = p;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input string tag, input logic [31:0] a, b, c, input logic [6:0] r,
                       input logic [1:0] iz, input logic dm, input logic [7:0] p,
                       input logic [34:0] expv);
        drive(a, b, c, r, iz, dm, p);
        check(tag, expv);
        check({tag, " model"}, model(a, b, c, r, iz, dm, p));
    endtask

    task automatic t_reset;
        check("R1 reset state", 35'd0);
    endtask

    task automatic t_order_directed;
        // order C,A,B: A qNaN, C sNaN -> C quieted
        run("R3 order CAB", 32'h7FC00011, NUM_ONE, 32'h7F800022, 7'h12, 2'd1, 1'b0, 8'h7F,
            {1'b1, 1'b1, 1'b0, 32'h7FC00022});
        // order A,B,C without preference -> A
        run("R4 no pref", 32'h7FC00011, NUM_ONE, 32'h7F800022, 7'h24, 2'd1, 1'b0, 8'h7F,
            {1'b1, 1'b1, 1'b0, 32'h7FC00011});
        // order A,B,C with preference -> sNaN C wins
        run("R4 snan pref", 32'h7FC00011, NUM_ONE, 32'h7F800022, 7'h64, 2'd1, 1'b0, 8'h7F,
            {1'b1, 1'b1, 1'b0, 32'h7FC00022});
        // preference set but no sNaN present: order B first
        run("R4 pref no snan", 32'h7FC00011, 32'hFFC00033, NUM_ONE, 7'h61, 2'd1, 1'b0, 8'h7F,
            {1'b1, 1'b0, 1'b0, 32'hFFC00033});
    endtask

    task automatic t_order_sweep;
        logic [31:0] v [3];
        logic [6:0]  r;
        int          sel;
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                for (int k = 0; k < 3; k++) begin
                    if (i == j || j == k || i == k) continue;
                    for (int sp = 0; sp < 2; sp++)
                        for (int combo = 0; combo < 27; combo++) begin
                            for (int o = 0; o < 3; o++) begin
                                sel = (combo / (o == 0 ? 1 : (o == 1 ? 3 : 9))) % 3;
                                if (sel == 0)      v[o] = NUM_ONE + 32'(o);
                                else if (sel == 1) v[o] = 32'h7FC00100 + 32'(o);
                                else               v[o] = 32'h7F800100 + 32'(o);
                            end
                            r = {sp[0], k[1:0], j[1:0], i[1:0]};
                            drive(v[0], v[1], v[2], r, 2'd1, 1'b0, 8'h7F);
                            check($sformatf("R3 R4 R12 sweep r=%h combo=%0d", r, combo),
                                  model(v[0], v[1], v[2], r, 2'd1, 1'b0, 8'h7F));
                        end
                end
    endtask

    task automatic t_no_rule;
        run("R5 zero rule", NUM_ONE, 32'h7FC00005, NUM_ONE, 7'h00, 2'd1, 1'b0, 8'h7F,
            {1'b1, 1'b0, 1'b1, FAULT_V});
        run("R5 unmatched fields", 32'h7F800009, NUM_ONE, NUM_ONE, 7'h3F, 2'd1, 1'b0, 8'h7F,
            {1'b1, 1'b1, 1'b1, FAULT_V});
        run("R12 zero rule no nan", NUM_ONE, NUM_ONE, NUM_ONE, 7'h00, 2'd0, 1'b0, 8'h00,
            35'd0);
    endtask

    task automatic t_dnan_mode;
        run("R6 mode pat FF", 32'h7FC00011, NUM_ONE, 32'h7F800022, 7'h00, 2'd0, 1'b1, 8'hFF,
            {1'b1, 1'b1, 1'b0, 32'hFFFFFFFF});
        run("R9 pat 41", 32'h7FC00011, NUM_ONE, NUM_ONE, 7'h24, 2'd1, 1'b1, 8'h41,
            {1'b1, 1'b0, 1'b0, 32'h7FC1FFFF});
        run("R9 pat C0", NUM_ONE, 32'h7FC00011, NUM_ONE, 7'h24, 2'd1, 1'b1, 8'hC0,
            {1'b1, 1'b0, 1'b0, 32'hFFC00000});
        run("R9 pat 01", NUM_ONE, NUM_ONE, 32'h7FC00011, 7'h24, 2'd1, 1'b1, 8'h01,
            {1'b1, 1'b0, 1'b0, 32'h7F81FFFF});
    endtask

    task automatic t_pat_zero;
        run("R10 pat 00", 32'h7FC00011, NUM_ONE, NUM_ONE, 7'h24, 2'd1, 1'b1, 8'h00,
            {1'b1, 1'b0, 1'b1, FAULT_V});
        run("R10 pat 80", POS_INF, 32'h0, NUM_ONE, 7'h24, 2'd1, 1'b0, 8'h80,
            {1'b1, 1'b1, 1'b1, FAULT_V});
    endtask

    task automatic t_izn;
        run("R7 rule0", POS_INF, 32'h0, 32'h7FC00033, 7'h24, 2'd0, 1'b0, 8'h7F,
            {1'b1, 1'b1, 1'b1, FAULT_V});
        run("R7 rule1", POS_INF, 32'h0, 32'h7F800033, 7'h24, 2'd1, 1'b0, 8'h7F,
            {1'b1, 1'b1, 1'b0, 32'h7FC00033});
        run("R7 rule2", 32'h80000000, 32'hFF800000, 32'h7F800033, 7'h24, 2'd2, 1'b0, 8'h7F,
            {1'b1, 1'b1, 1'b0, 32'h7FFFFFFF});
        run("R7 rule3 quiet", POS_INF, 32'h0, 32'h7FC00033, 7'h24, 2'd3, 1'b0, 8'h7F,
            {1'b1, 1'b1, 1'b0, 32'h7FFFFFFF});
        run("R7 rule3 signal", 32'h0, POS_INF, 32'h7F800033, 7'h24, 2'd3, 1'b0, 8'h7F,
            {1'b1, 1'b1, 1'b0, 32'h7FC00033});
    endtask

    task automatic t_infzero_num;
        run("R8 inf*0+num", POS_INF, 32'h0, NUM_ONE, 7'h00, 2'd0, 1'b0, 8'h40,
            {1'b1, 1'b1, 1'b0, 32'h7FC00000});
        run("R11 inf*num no nan", POS_INF, NUM_ONE, NUM_ONE, 7'h24, 2'd1, 1'b0, 8'h40,
            35'd0);
    endtask

    task automatic t_invalid;
        run("R11 quiet only", 32'h7FC00011, 32'h7FC00022, NUM_ONE, 7'h24, 2'd1, 1'b0, 8'h7F,
            {1'b1, 1'b0, 1'b0, 32'h7FC00011});
        run("R11 snan in mode", NUM_ONE, 32'h7F800002, NUM_ONE, 7'h00, 2'd0, 1'b1, 8'h7F,
            {1'b1, 1'b1, 1'b0, 32'h7FFFFFFF});
    endtask

    task automatic t_hold;
        run("R1 load", 32'h7FC00011, NUM_ONE, NUM_ONE, 7'h24, 2'd1, 1'b0, 8'h7F,
            {1'b1, 1'b0, 1'b0, 32'h7FC00011});
        @(negedge clk);
        op_a = NUM_ONE; op_c = 32'h7F800044; prop_rule = 7'h00;
        @(negedge clk);
        @(negedge clk);
        check("R1 hold without strobe", {1'b1, 1'b0, 1'b0, 32'h7FC00011});
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order_directed();
        t_order_sweep();
        t_no_rule();
        t_dnan_mode();
        t_pat_zero();
        t_izn();
        t_infzero_num();
        t_invalid();
        t_hold();
        finish_run();
    end

endmodule